// File: doc/BRIEF.md
# I2C SCL Prescaled Clock Generator

This block derives the serial clock of an I2C controller from a fast core clock. A prescale value P sets the length of an internal phase tick to P + 1 core cycles. Every SCL period holds five such ticks plus a fixed overhead of eight core cycles, which is added to the last tick. A full period therefore lasts 5(P + 1) + 8 core cycles. Software computes P from the core-to-SCL ratio N = ceil(f_core / f_scl) as P = ((N - 8) / 5) - 1. The reset value of P is computed at elaboration from the nominal core and bus rates (133 MHz core, 100 kHz bus, giving 263). Bus rates above 400 kHz are rejected at elaboration.

The transaction engine raises `run_req` to ask for clocking. The generator opens with a half period in which SCL stays released and a start strobe marks the point to pull SDA low. It then produces full periods. In each period SCL is pulled low for ticks 0 and 1 and released for ticks 2 to 4. A data-change strobe marks tick 0 and a sample strobe marks tick 3. When `run_req` is low at the end of a period, one closing period follows with a stop strobe in place of the sample strobe, and the block then goes idle. While SCL is released but a target still holds it low, the tick counter halts.

The block is configured through a small word-addressed write port. Word 0 holds the prescale value. Word 1 is the control word: bit 6 is the run enable and bit 8 is a self-clearing controller reset.

Top module: `i2c_scl_prescaler`

## Requirements
- R1: After reset, and whenever the generator is enabled with `run_req` low and idle, `scl_pull_low` is 0, `clk_busy` is 0 and no strobe is raised.
- R2: With prescale P, consecutive `stb_change` pulses of a running transfer lie exactly 5(P+1)+8 core cycles apart.
- R3: In each full period, `scl_pull_low` is 1 for exactly 2(P+1) cycles, beginning in the cycle of `stb_change`, and 0 for the rest of the period.
- R4: `stb_sample` rises exactly 3(P+1) cycles after `stb_change`, while SCL is released. At most one strobe is high in any cycle.
- R5: When `run_req` is seen high while the generator is idle and enabled, `stb_start` rises P+2 cycles after the cycle in which `run_req` was raised, with SCL released. The first `stb_change` follows 2(P+1)+8 cycles after `stb_start`.
- R6: If `run_req` is low when a period ends, exactly one more period follows. It begins with `stb_change`, has `stb_stop` 3(P+1) cycles after that strobe instead of `stb_sample`, and `clk_busy` falls 2(P+1)+8 cycles after `stb_stop`.
- R7: While the tick index is 2, 3 or 4 and `scl_sense` is 0, the tick counter holds, so each held cycle delays the next strobe by one cycle. A low `scl_sense` during ticks 0 and 1 has no effect.
- R8: A write to word address 0 loads the prescale value from data bits [PRE_W-1:0]. A write to word address 1 sets the enable from data bit 6. Once the enable is 0, the generator is idle with SCL released from the next cycle on.
- R9: A write to word address 1 with data bit 8 set restores the prescale reset value (period 1328 cycles at the default rates) and clears the enable, even if bit 6 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Word address of the write (0 prescale, 1 control) |
| cfg_wdata | input | DATA_W | Write data |
| run_req | input | 1 | Transaction engine asks for SCL clocking |
| scl_sense | input | 1 | Synchronised level read back from the SCL line |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| phase_tick | output | 3 | Current tick index 0 to 4 |
| stb_start | output | 1 | START setup point (SCL released, SDA may fall) |
| stb_change | output | 1 | Data change point at tick 0 |
| stb_sample | output | 1 | Data sample point at tick 3 |
| stb_stop | output | 1 | STOP point at tick 3 of the closing period |
| clk_busy | output | 1 | Generator is producing a transfer |

## Verification
The stretch hold and the end of a tick can fall in the same cycle: the counter reaches its limit in the cycle in which `scl_sense` is low. The bench provokes this by pulling the sensed line low for exactly one cycle, the last cycle of tick 2. It judges the result by the sample strobe, which must come one cycle later than without the stretch, not in the original cycle and not twice. A second overlap is the reset bit and the enable bit written in the same control word. There the reset must win: the block must go idle and, once re-enabled, must run with the restored default period.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HEAD = 2'd1,
      SEQ_RUN  = 2'd2,
      SEQ_TAIL = 2'd3
   } seq_kind_t;

   localparam int TICKS_PER_PERIOD = 5;
   localparam int TICK_W           = 3;

   // Prescale from core rate, bus rate and fixed per-period overhead.
   function automatic int calc_prescale(input longint core_hz,
                                        input longint scl_hz,
                                        input int     ovh);
      longint ratio;
      ratio = (core_hz + scl_hz - 1) / scl_hz;
      return int'(((ratio - longint'(ovh)) / TICKS_PER_PERIOD) - 1);
   endfunction

endpackage

// File: rtl/i2c_sclgen_regs.sv
module i2c_sclgen_regs #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int PRE_W       = 12,
   parameter int PRE_DEFAULT = 263,
   parameter int ADDR_PRE    = 0,
   parameter int ADDR_CTRL   = 1,
   parameter int EN_BIT      = 6,
   parameter int RST_BIT     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRE_W-1:0]  prescale,
   output logic              enable
);

   localparam logic [PRE_W-1:0]  PRE_RST  = PRE_W'(PRE_DEFAULT);
   localparam logic [ADDR_W-1:0] A_PRE    = ADDR_W'(ADDR_PRE);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);

   if (PRE_W < 4 || PRE_W > DATA_W || RST_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_bad_width
      $error("i2c_sclgen_regs: field layout does not fit the data width");
   end
   if (ADDR_PRE == ADDR_CTRL) begin : g_bad_map
      $error("i2c_sclgen_regs: prescale and control share an address");
   end

   logic hit_pre, hit_ctrl, ctl_reset;
   logic unused_wdata;

   assign hit_pre      = we && (addr == A_PRE);
   assign hit_ctrl     = we && (addr == A_CTRL);
   assign ctl_reset    = hit_ctrl && wdata[RST_BIT];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prescale <= PRE_RST;
         enable   <= 1'b0;
      end else if (ctl_reset) begin
         prescale <= PRE_RST;
         enable   <= 1'b0;
      end else if (hit_ctrl) begin
         enable   <= wdata[EN_BIT];
      end else if (hit_pre) begin
         prescale <= wdata[PRE_W-1:0];
      end
   end

   assert_softrst_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_CTRL && wdata[RST_BIT]) |=> (!enable && prescale == PRE_RST));

   assert_pre_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_PRE) |=> (prescale == $past(wdata[PRE_W-1:0])));

endmodule

// File: rtl/i2c_sclgen_tick.sv
module i2c_sclgen_tick
   import i2c_sclgen_pkg::*;
#(
   parameter int PRE_W      = 12,
   parameter int OVH_CYC    = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load_head,
   input  logic              active,
   input  logic [PRE_W-1:0]  prescale,
   input  logic              scl_sense,
   output logic [TICK_W-1:0] tick_idx,
   output logic              tick_last,
   output logic              hold
);

   localparam int                CW       = PRE_W + 1;
   localparam logic [TICK_W-1:0] LAST_T   = TICK_W'(TICKS_PER_PERIOD - 1);
   localparam logic [TICK_W-1:0] FIRST_HI = TICK_W'(2);

   if (OVH_CYC < 0 || OVH_CYC >= (1 << PRE_W)) begin : g_bad_ovh
      $error("i2c_sclgen_tick: overhead does not fit the counter");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = {1'b0, prescale} + ((tick_idx == LAST_T) ? CW'(OVH_CYC) : '0);

   // Stretch variant: hold while released but read back low.
   if (STRETCH_EN) begin : g_stretch
      assign hold = active && (tick_idx >= FIRST_HI) && !scl_sense;
   end else begin : g_no_stretch
      logic unused_sense;
      assign unused_sense = scl_sense;
      assign hold = 1'b0;
   end

   assign tick_last = active && !hold && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         tick_idx <= '0;
      end else if (clr) begin
         cnt      <= '0;
         tick_idx <= '0;
      end else if (load_head) begin
         cnt      <= '0;
         tick_idx <= FIRST_HI;
      end else if (tick_last) begin
         cnt      <= '0;
         tick_idx <= (tick_idx == LAST_T) ? '0 : tick_idx + 1'b1;
      end else if (active && !hold) begin
         cnt      <= cnt + 1'b1;
      end
   end

   assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> ($stable(cnt) && $stable(tick_idx)));

   assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_idx <= LAST_T);

endmodule

// File: rtl/i2c_sclgen_seq.sv
module i2c_sclgen_seq
   import i2c_sclgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              run_req,
   input  logic [TICK_W-1:0] tick_idx,
   input  logic              tick_last,
   output logic              active,
   output logic              load_head,
   output logic              clr,
   output logic              scl_pull_low,
   output logic              stb_start,
   output logic              stb_change,
   output logic              stb_sample,
   output logic              stb_stop
);

   localparam logic [TICK_W-1:0] T_PRE_SAMPLE = TICK_W'(2);
   localparam logic [TICK_W-1:0] T_END        = TICK_W'(TICKS_PER_PERIOD - 1);

   seq_kind_t kind;

   assign active       = (kind != SEQ_IDLE);
   assign load_head    = enable && (kind == SEQ_IDLE) && run_req;
   assign clr          = !enable;
   assign scl_pull_low = active && (tick_idx < T_PRE_SAMPLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind       <= SEQ_IDLE;
         stb_start  <= 1'b0;
         stb_change <= 1'b0;
         stb_sample <= 1'b0;
         stb_stop   <= 1'b0;
      end else if (!enable) begin
         kind       <= SEQ_IDLE;
         stb_start  <= 1'b0;
         stb_change <= 1'b0;
         stb_sample <= 1'b0;
         stb_stop   <= 1'b0;
      end else begin
         stb_start  <= 1'b0;
         stb_change <= 1'b0;
         stb_sample <= 1'b0;
         stb_stop   <= 1'b0;
         if (kind == SEQ_IDLE) begin
            if (run_req) kind <= SEQ_HEAD;
         end else if (tick_last) begin
            if (tick_idx == T_PRE_SAMPLE) begin
               stb_start  <= (kind == SEQ_HEAD);
               stb_sample <= (kind == SEQ_RUN);
               stb_stop   <= (kind == SEQ_TAIL);
            end else if (tick_idx == T_END) begin
               if (kind == SEQ_TAIL) begin
                  kind <= SEQ_IDLE;
               end else begin
                  kind       <= run_req ? SEQ_RUN : SEQ_TAIL;
                  stb_change <= 1'b1;
               end
            end
         end
      end
   end

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb_start, stb_change, stb_sample, stb_stop}));

   assert_change_while_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_change |-> scl_pull_low);

   assert_mid_high_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_sample || stb_start || stb_stop) |-> !scl_pull_low);

   assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!active && !scl_pull_low));

   assert_start_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !active && run_req) |=> (active && !scl_pull_low));

endmodule

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler
   import i2c_sclgen_pkg::*;
#(
   parameter longint CORE_HZ    = 133_000_000,
   parameter longint SCL_HZ     = 100_000,
   parameter int     OVH_CYC    = 8,
   parameter int     PRE_W      = 12,
   parameter int     ADDR_W     = 5,
   parameter int     DATA_W     = 32,
   parameter bit     STRETCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              run_req,
   input  logic              scl_sense,
   output logic              scl_pull_low,
   output logic [2:0]        phase_tick,
   output logic              stb_start,
   output logic              stb_change,
   output logic              stb_sample,
   output logic              stb_stop,
   output logic              clk_busy
);

   localparam int PRE_DEFAULT = calc_prescale(CORE_HZ, SCL_HZ, OVH_CYC);

   if (SCL_HZ <= 0 || SCL_HZ > 400_000) begin : g_bad_rate
      $error("i2c_scl_prescaler: bus rate outside the supported range");
   end
   if (PRE_DEFAULT < 0 || PRE_DEFAULT >= (1 << PRE_W)) begin : g_bad_default
      $error("i2c_scl_prescaler: default prescale does not fit PRE_W");
   end

   logic [PRE_W-1:0]  prescale;
   logic              enable;
   logic              active, load_head, clr, tick_last, hold;
   logic [TICK_W-1:0] tick_idx;
   logic              unused_hold;

   i2c_sclgen_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PRE_W       (PRE_W),
      .PRE_DEFAULT (PRE_DEFAULT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .prescale (prescale),
      .enable   (enable)
   );

   i2c_sclgen_tick #(
      .PRE_W      (PRE_W),
      .OVH_CYC    (OVH_CYC),
      .STRETCH_EN (STRETCH_EN)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .load_head (load_head),
      .active    (active),
      .prescale  (prescale),
      .scl_sense (scl_sense),
      .tick_idx  (tick_idx),
      .tick_last (tick_last),
      .hold      (hold)
   );

   i2c_sclgen_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .run_req      (run_req),
      .tick_idx     (tick_idx),
      .tick_last    (tick_last),
      .active       (active),
      .load_head    (load_head),
      .clr          (clr),
      .scl_pull_low (scl_pull_low),
      .stb_start    (stb_start),
      .stb_change   (stb_change),
      .stb_sample   (stb_sample),
      .stb_stop     (stb_stop)
   );

   assign phase_tick  = tick_idx;
   assign clk_busy    = active;
   assign unused_hold = hold;

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_busy && !$past(clk_busy)) |-> (!scl_pull_low && !stb_change && !stb_sample));

endmodule

// File: tb/i2c_scl_prescaler_test.sv
`timescale 1ns/1ps
module i2c_scl_prescaler_test;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;

   // P, period, low cycles, change->sample, start->change (= stop->idle), req->start
   localparam int VEC [0:4][0:5] = '{
      '{ 0, 13,  2,  3, 10,  2},
      '{ 1, 18,  4,  6, 12,  3},
      '{ 3, 28,  8, 12, 16,  5},
      '{ 6, 43, 14, 21, 22,  8},
      '{10, 63, 22, 33, 30, 12}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic              run_req = 1'b0;
   logic              stretch = 1'b0;
   logic              scl_sense;
   logic              scl_pull_low, stb_start, stb_change, stb_sample, stb_stop, clk_busy;
   logic [2:0]        phase_tick;

   assign scl_sense = !scl_pull_low && !stretch;

   i2c_scl_prescaler uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .run_req      (run_req),
      .scl_sense    (scl_sense),
      .scl_pull_low (scl_pull_low),
      .phase_tick   (phase_tick),
      .stb_start    (stb_start),
      .stb_change   (stb_change),
      .stb_sample   (stb_sample),
      .stb_stop     (stb_stop),
      .clk_busy     (clk_busy)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int k);
      case (k)
         0: return stb_start;
         1: return stb_change;
         2: return stb_sample;
         3: return stb_stop;
         4: return !clk_busy;
         default: return 1'b0;
      endcase
   endfunction

   task automatic wait_for(input int k, output int t);
      t = -1;
      for (int g = 0; g < 6000; g++) begin
         @(negedge clk);
         if (pick(k)) begin
            t = cyc;
            return;
         end
      end
   endtask

   task automatic reg_write(input int a, input int d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = ADDR_W'(a);
      cfg_wdata = DATA_W'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Called at the negedge of a change strobe; runs to the next change strobe.
   task automatic measure(input int c0, output int per, output int low, output int samp);
      per  = -1;
      samp = -1;
      low  = scl_pull_low ? 1 : 0;
      for (int g = 0; g < 6000; g++) begin
         @(negedge clk);
         if (stb_change) begin
            per = cyc - c0;
            return;
         end
         if (scl_pull_low) low = low + 1;
         if (stb_sample) samp = cyc - c0;
      end
   endtask

   initial begin
      int t_req, ts, tc, tc1, tc2, tst, tid, per, low, samp, nstb, nlow;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset pull_low", int'(scl_pull_low), 0);
      check("R1 reset busy", int'(clk_busy), 0);
      check("R1 reset strobes", int'(stb_start | stb_change | stb_sample | stb_stop), 0);

      // R1/R8: enabled, no run request
      reg_write(1, 32'h40);
      nstb = 0;
      nlow = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         nstb += int'(stb_start | stb_change | stb_sample | stb_stop | clk_busy);
         nlow += int'(scl_pull_low);
      end
      check("R1 idle enabled activity", nstb, 0);
      check("R1 idle enabled pull_low", nlow, 0);

      // Table of prescale values
      for (int v = 0; v < 5; v++) begin
         reg_write(0, VEC[v][0]);
         @(negedge clk);
         run_req = 1'b1;
         t_req = cyc;
         wait_for(0, ts);
         check("R5 request to start strobe", ts - t_req, VEC[v][5]);
         wait_for(1, tc);
         check("R5 start to first change", tc - ts, VEC[v][4]);
         measure(tc, per, low, samp);
         check("R2 period", per, VEC[v][1]);
         check("R3 low cycles", low, VEC[v][2]);
         check("R4 change to sample", samp, VEC[v][3]);
         tc1 = cyc;
         run_req = 1'b0;
         wait_for(1, tc2);
         check("R6 closing period follows", tc2 - tc1, VEC[v][1]);
         wait_for(3, tst);
         check("R6 change to stop", tst - tc2, VEC[v][3]);
         wait_for(4, tid);
         check("R6 stop to idle", tid - tst, VEC[v][4]);
      end

      // R7: target stretch, P = 3
      reg_write(0, 3);
      run_req = 1'b1;
      wait_for(1, tc);
      repeat (8) @(negedge clk);
      stretch = 1'b1;
      repeat (5) @(negedge clk);
      stretch = 1'b0;
      wait_for(2, ts);
      check("R7 five-cycle stretch delays sample", ts - tc, 17);

      // R7: stretch coincides with the last cycle of tick 2
      wait_for(1, tc);
      repeat (11) @(negedge clk);
      stretch = 1'b1;
      @(negedge clk);
      stretch = 1'b0;
      wait_for(2, ts);
      check("R7 stretch at tick expiry", ts - tc, 13);

      // R7: low sense while SCL is driven low has no effect
      wait_for(1, tc);
      stretch = 1'b1;
      repeat (4) @(negedge clk);
      stretch = 1'b0;
      wait_for(2, ts);
      check("R7 low sense in ticks 0-1 ignored", ts - tc, 12);

      // R9: reset bit together with enable bit
      reg_write(1, 32'h140);
      @(negedge clk);
      check("R9 reset idles busy", int'(clk_busy), 0);
      check("R9 reset releases SCL", int'(scl_pull_low), 0);
      reg_write(1, 32'h40);
      wait_for(1, tc);
      measure(tc, per, low, samp);
      check("R9 default period", per, 1328);
      check("R9 default low cycles", low, 528);
      check("R9 default sample offset", samp, 792);

      // R8: clearing enable mid-transfer
      reg_write(1, 32'h0);
      @(negedge clk);
      check("R8 disable idles busy", int'(clk_busy), 0);
      check("R8 disable releases SCL", int'(scl_pull_low), 0);
      nstb = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         nstb += int'(stb_start | stb_change | stb_sample | stb_stop | scl_pull_low);
      end
      check("R8 disabled with run_req high stays quiet", nstb, 0);
      run_req = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule